// File: doc/BRIEF.md
# Stretched-High Clock Shaper

This block derives a slow core clock from a fast reference clock. Each output period opens with a low phase that lasts exactly one reference cycle. A high phase follows, lasting a programmable number of reference cycles. The low phase stays fixed whatever length is chosen, and it covers supply-rail recovery and next-state evaluation in the downstream logic. The long high phase is the window in which that logic can sit power-gated. Raising the high length lowers the output frequency and raises its duty cycle, while the evaluation window stays the same.

A new high length is presented on `len_in` and captured by a one-cycle `len_load` strobe. The captured value governs whole periods only. It never cuts short or stretches a high phase that has already begun. A length of zero is treated as one, which gives a square wave at half the reference rate. The output is the value of a single flop clocked by the reference clock, so it carries no combinational glitches.

Top module: `duty_clk_shaper`

## Requirements
- R1: Each output period lasts 1 + L reference cycles, where L is the effective high length in force for that period.
- R2: In every period the output is low for exactly one reference cycle, which is the first cycle of the period, and high for the remaining L cycles.
- R3: While `rst_n` is low the output is low. After release, the output stays low until the first rising reference edge and is high after that edge.
- R4: A value captured by `len_load` at a rising edge first governs the period whose low cycle ends at a later edge. When several strobes occur before that edge, the last one wins.
- R5: A strobe taken during a high phase does not change that phase's length, so no shortened or lengthened high phase occurs.
- R6: A captured length of 0 is treated as 1, giving one low cycle followed by one high cycle.
- R7: Out of reset, the high length is the parameter `RESET_LEN`, which is 1 by default.
- R8: `len_in` has no effect while `len_load` is low.
- R9: The largest length, 2^CNT_W − 1, produces a high phase of exactly that many reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| len_in | input | CNT_W | Requested high-phase length in reference cycles |
| len_load | input | 1 | One-cycle strobe that captures `len_in` |
| clk_out | output | 1 | Shaped output clock, driven directly by a flop |

## Verification
The bench builds the block with CNT_W = 8 and RESET_LEN = 4. With CNT_W = 8 the maximum length of 255 fits in a short run, so the full-scale high phase and a strobe landing in the middle of it can both be observed in full. The non-default reset length shows that the out-of-reset period comes from the parameter and not from a hard-wired one. The bench also measures the low and high widths of whole periods for lengths 0, 1, 4, 100 and 255. It strobes a new length once during a long high phase, once during a low cycle, and twice in a row.

// File: rtl/dcm_pkg.sv
`timescale 1ns/1ps
package dcm_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/dcm_len_reg.sv
`timescale 1ns/1ps
// Holds the requested length and the length in force for the current period.
module dcm_len_reg #(
  parameter int W         = 32,
  parameter int RESET_LEN = 1
) (
  input  logic         clk_ref,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] len_in,
  input  logic         take,
  output logic [W-1:0] active_len
);
  localparam logic [W-1:0] RST_VAL = W'(RESET_LEN);

  // A zero length is promoted to one cycle.
  function automatic logic [W-1:0] eff_len(input logic [W-1:0] v);
    return (v == '0) ? W'(1) : v;
  endfunction

  logic [W-1:0] pending_q;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) pending_q <= RST_VAL;
    else if (load_en) pending_q <= len_in;
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) active_len <= eff_len(RST_VAL);
    else if (take) active_len <= eff_len(pending_q);
  end
endmodule

// File: rtl/dcm_phase_gen.sv
`timescale 1ns/1ps
// Produces one low cycle, then active_len high cycles, repeating.
module dcm_phase_gen #(
  parameter int W = 32
) (
  input  logic         clk_ref,
  input  logic         rst_n,
  input  logic [W-1:0] active_len,
  output logic         clk_q,
  output logic         leave_low,
  output logic         end_high
);
  import dcm_pkg::*;

  phase_e       ph_q;
  logic [W-1:0] cnt_q;

  function automatic logic high_finished(input logic [W-1:0] c, input logic [W-1:0] len);
    return c >= len;
  endfunction

  assign leave_low = (ph_q == PH_LOW);
  assign end_high  = (ph_q == PH_HIGH) && high_finished(cnt_q, active_len);
  assign clk_q     = (ph_q == PH_HIGH);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_LOW;
      cnt_q <= '0;
    end else if (leave_low) begin
      ph_q  <= PH_HIGH;
      cnt_q <= W'(1);
    end else if (end_high) begin
      ph_q  <= PH_LOW;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + W'(1);
    end
  end
endmodule

// File: rtl/duty_clk_shaper.sv
`timescale 1ns/1ps
module duty_clk_shaper #(
  parameter int CNT_W     = 32,
  parameter int RESET_LEN = 1
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] len_in,
  input  logic             len_load,
  output logic             clk_out
);
  logic [CNT_W-1:0] active_len;
  logic             leave_low;  // period boundary: low cycle ends at next edge
  logic             end_high;   // last high cycle of the period

  dcm_len_reg #(.W(CNT_W), .RESET_LEN(RESET_LEN)) u_len (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .load_en    (len_load),
    .len_in     (len_in),
    .take       (leave_low),
    .active_len (active_len)
  );

  dcm_phase_gen #(.W(CNT_W)) u_phase (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .active_len (active_len),
    .clk_q      (clk_out),
    .leave_low  (leave_low),
    .end_high   (end_high)
  );
endmodule

// File: rtl/dcm_checker.sv
`timescale 1ns/1ps
module dcm_checker #(
  parameter int W = 32
) (
  input logic         clk_ref,
  input logic         rst_n,
  input logic         clk_out,
  input logic [W-1:0] active_len,
  input logic         leave_low,
  input logic         end_high
);
  logic [W:0] hi_run;  // high cycles already seen in the current high phase

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) hi_run <= '0;
    else if (clk_out) hi_run <= hi_run + (W+1)'(1);
    else hi_run <= '0;
  end

  AST_LOW_SINGLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !clk_out |=> clk_out);  // R2

  AST_HIGH_EXACT: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (clk_out && end_high) |-> (hi_run + (W+1)'(1) == (W+1)'(active_len)));  // R1

  AST_NO_RUNT: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (clk_out && !end_high) |-> (hi_run + (W+1)'(1) < (W+1)'(active_len)));  // R5

  AST_LEN_HELD: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (clk_out && !end_high) |=> $stable(active_len));  // R4

  AST_LEN_NONZERO: assert property (@(posedge clk_ref) disable iff (!rst_n)
    leave_low |=> (active_len != '0));  // R6

  always_ff @(posedge clk_ref) begin
    if (!rst_n) AST_RESET_LOW: assert (!clk_out);  // R3
  end
endmodule

bind duty_clk_shaper dcm_checker #(.W(CNT_W)) u_chk (
  .clk_ref    (clk_ref),
  .rst_n      (rst_n),
  .clk_out    (clk_out),
  .active_len (active_len),
  .leave_low  (leave_low),
  .end_high   (end_high)
);

// File: tb/duty_clk_shaper_test.sv
`timescale 1ns/1ps
module duty_clk_shaper_test;
  localparam int W       = 8;
  localparam int RST_LEN = 4;

  logic         clk_ref  = 1'b0;
  logic         rst_n    = 1'b0;
  logic         len_load = 1'b0;
  logic [W-1:0] len_in   = '0;
  logic         clk_out;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    run_cmp = 0;
  bit    done    = 0;
  string tag     = "R3";

  always #2 clk_ref = ~clk_ref;  // 250 MHz

  duty_clk_shaper #(.CNT_W(W), .RESET_LEN(RST_LEN)) uut (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .len_in   (len_in),
    .len_load (len_load),
    .clk_out  (clk_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: a queue of expected output levels, refilled once per period.
  int q[$];
  int pend;
  bit exp_out = 1'b0;

  function automatic int as_len(input int v);
    if (v == 0) return 1;
    return v;
  endfunction

  always @(posedge clk_ref) begin
    if (!rst_n) begin
      q.delete();
      pend    = RST_LEN;
      exp_out = 1'b0;
    end else begin
      if (q.size() == 0) begin
        for (int i = 0; i < as_len(pend); i++) q.push_back(1);
        q.push_back(0);
      end
      exp_out = (q.pop_front() != 0);
      if (len_load) pend = int'(len_in);
    end
  end

  always @(negedge clk_ref) begin
    if (!rst_n) check(clk_out === 1'b0, "R3 reset level", int'(clk_out), 0);
    else if (run_cmp) check(clk_out === exp_out, tag, int'(clk_out), int'(exp_out));
  end

  always @(posedge clk_ref) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic load(input int v);
    @(negedge clk_ref);
    len_in   = W'(v);
    len_load = 1'b1;
    @(negedge clk_ref);
    len_load = 1'b0;
  endtask

  // Skip to a fresh period boundary, then measure one whole period.
  task automatic measure(input int exp_hi, input string req);
    int lo = 0;
    int hi = 0;
    @(negedge clk_ref);
    while (clk_out !== 1'b1) @(negedge clk_ref);
    while (clk_out !== 1'b0) @(negedge clk_ref);
    while (clk_out === 1'b0) begin lo++; @(negedge clk_ref); end
    while (clk_out === 1'b1) begin hi++; @(negedge clk_ref); end
    check(lo == 1, {req, " low width"}, lo, 1);
    check(hi == exp_hi, {req, " high width"}, hi, exp_hi);
  endtask

  initial begin
    int h;
    repeat (3) @(negedge clk_ref);
    rst_n = 1'b1;
    check(clk_out === 1'b0, "R3 first cycle low", int'(clk_out), 0);
    run_cmp = 1;
    @(negedge clk_ref);
    check(clk_out === 1'b1, "R3 high after first edge", int'(clk_out), 1);

    tag = "R7";
    measure(RST_LEN, "R7");
    measure(RST_LEN, "R7");

    tag = "R8";
    len_in = W'(9);
    measure(RST_LEN, "R8");

    tag = "R1";
    load(1);
    measure(1, "R1");
    measure(1, "R2");

    tag = "R6";
    load(0);
    measure(1, "R6");

    tag = "R1";
    load(100);
    measure(100, "R1");

    tag = "R9";
    load(255);
    measure(255, "R9");

    // R5: strobe in the middle of a 255-cycle high phase.
    tag = "R5";
    h = 0;
    @(negedge clk_ref);
    while (clk_out === 1'b1) begin
      h++;
      if (h == 40) begin len_in = W'(3); len_load = 1'b1; end
      else len_load = 1'b0;
      @(negedge clk_ref);
    end
    len_load = 1'b0;
    check(h == 255, "R5 high phase not cut", h, 255);
    measure(3, "R4");

    // R4: two strobes in a row, the last wins.
    tag = "R4";
    load(50);
    load(7);
    measure(7, "R4");

    // R4: strobe at the edge that ends a low cycle applies one period later.
    len_in   = W'(20);
    len_load = 1'b1;
    @(negedge clk_ref);
    len_load = 1'b0;
    h = 0;
    while (clk_out === 1'b1) begin h++; @(negedge clk_ref); end
    check(h == 7, "R4 strobe during low deferred", h, 7);
    measure(20, "R4");

    repeat (4) @(negedge clk_ref);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule